// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block turns one character at a time into an asynchronous serial frame on a single output line. A character is handed over on a valid/ready interface together with static framing settings. The framing settings are the character length (5 to 8 bits), whether a parity bit is added, whether that parity is even or odd, and the length of the stop period (one, one and a half or two bit times). The block latches the character and the settings at the handshake. It then drives a low start bit, the data bits lowest first, the optional parity bit and a high stop period. After that it reports ready again.

Timing comes from an external enable pulse, `os_tick`, that runs at sixteen times the bit rate. A bit lasts sixteen ticks, so a stop period of one and a half bits is exactly twenty-four ticks. Between ticks the frame does not advance, and the line holds its level. Baud-rate division from the system clock is left to the surrounding logic.

Back-pressure rules: `in_ready` is high only while no frame is in progress. A character is taken on a clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, `in_valid` and `in_data` have no effect, and the source must keep its character until the handshake. `in_ready` rises only once the full stop period has been sent.

Top module: `serial_tx_framer`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, `txd` is high and `in_ready` is high.
- R2: A character is accepted on a clock edge with `in_valid` and `in_ready` both high. From the next cycle `in_ready` is low and `txd` is low for 16 ticks (the start bit).
- R3: After the start bit, the data bits follow lowest bit first, 16 ticks each. The number of data bits is 5 plus the value of `cfg_len` (0 gives 5 bits, 3 gives 8 bits).
- R4: With `cfg_par_en` = 1, a 16-tick parity bit follows the data. With `cfg_par_odd` = 0 (even), it is the XOR of the sent data bits. With `cfg_par_odd` = 1 (odd), it is the inverse of that XOR. With `cfg_par_en` = 0, no parity bit is sent.
- R5: The stop period is high and lasts 16 ticks for `cfg_stop` = 0, 24 ticks for 1, and 32 ticks for 2 or 3. A whole frame therefore takes 16*(1+bits+parity) + stop ticks.
- R6: `in_ready` stays low until the whole stop period has been sent, so no start bit can begin sooner.
- R7: While `in_ready` is low, asserting `in_valid` has no effect on the frame in progress.
- R8: Data and all configuration inputs are sampled at the handshake. Changing them during a frame does not change that frame.
- R9: Data bits at or above the selected length are neither sent nor counted in the parity.
- R10: `txd` and `in_ready` change only in the cycle after an `os_tick` pulse or a handshake. Without ticks the frame is frozen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Enable pulse at 16 times the bit rate |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block idle and able to take a character |
| in_data | input | 8 | Character, bit 0 sent first |
| cfg_len | input | 2 | Character length code: bits = 5 + code |
| cfg_par_en | input | 1 | 1 adds a parity bit |
| cfg_par_odd | input | 1 | 0 even parity, 1 odd parity |
| cfg_stop | input | 2 | Stop period: 0 one bit, 1 one and a half, 2 or 3 two bits |
| txd | output | 1 | Serial line, high when idle |

## Verification
The checker watches, on every cycle, that the line is high while ready, that a handshake drops both the line and ready at once, and that nothing moves except after a tick or a handshake. It also counts the high ticks before each return to ready, to confirm that at least a full bit of stop has passed. The exact bit order, parity value, per-code stop length and total frame length depend on the character and settings. Only the bench's sweep can show these: it covers every length, parity and stop code at two tick rates. The bench also shows that settings scrambled mid-frame, loads attempted while busy and data bits above the chosen length have no effect.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_e;

  // Stop period in oversample ticks for a stop-length code.
  function automatic int unsigned stop_tick_count(input logic [1:0] code,
                                                  input int unsigned os);
    case (code)
      2'd0:    return os;
      2'd1:    return os + os / 2;
      default: return 2 * os;
    endcase
  endfunction

endpackage

// File: rtl/tx_frame_capture.sv
module tx_frame_capture
  import serial_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MIN_LEN    = 5,
  parameter int OVERSAMPLE = 16,
  parameter int LEN_W      = 2,
  parameter int IDX_W      = 4,
  parameter int CNT_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic [1:0]        cfg_stop,
  output logic              data_lsb,
  output logic              par_bit,
  output logic              par_en,
  output logic [IDX_W-1:0]  nbits,
  output logic [CNT_W-1:0]  stop_ticks
);

  logic [IDX_W-1:0]  req_nbits;
  logic [DATA_W-1:0] keep;
  logic [DATA_W-1:0] masked;
  logic              par_next;
  logic [DATA_W-1:0] shreg_q;

  assign req_nbits = IDX_W'(MIN_LEN) + IDX_W'(cfg_len);

  // Bits at or above the selected length are cleared before use.
  for (genvar i = 0; i < DATA_W; i++) begin : g_keep
    assign keep[i] = (IDX_W'(i) < req_nbits);
  end

  assign masked   = in_data & keep;
  assign par_next = (^masked) ^ cfg_par_odd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q    <= '0;
      par_bit    <= 1'b0;
      par_en     <= 1'b0;
      nbits      <= IDX_W'(MIN_LEN);
      stop_ticks <= CNT_W'(OVERSAMPLE);
    end else if (load) begin
      shreg_q    <= masked;
      par_bit    <= par_next;
      par_en     <= cfg_par_en;
      nbits      <= req_nbits;
      stop_ticks <= CNT_W'(stop_tick_count(cfg_stop, OVERSAMPLE));
    end else if (shift) begin
      shreg_q    <= shreg_q >> 1;
    end
  end

  assign data_lsb = shreg_q[0];

endmodule

// File: rtl/tx_tick_counter.sv
module tx_tick_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (tick) count <= count + 1'b1;
  end

endmodule

// File: rtl/tx_sequencer.sv
module tx_sequencer
  import serial_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int IDX_W      = 4,
  parameter int CNT_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             os_tick,
  input  logic             data_lsb,
  input  logic             par_bit,
  input  logic             par_en,
  input  logic [IDX_W-1:0] nbits,
  input  logic [CNT_W-1:0] stop_ticks,
  input  logic [CNT_W-1:0] count,
  output logic             in_ready,
  output logic             txd,
  output logic             load,
  output logic             shift,
  output logic             clr
);

  localparam logic [CNT_W-1:0] BIT_TICKS = CNT_W'(OVERSAMPLE);

  tx_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] seg_len;
  logic             seg_done;
  logic             last_bit;

  assign in_ready = (state_q == ST_IDLE);
  assign load     = in_valid && in_ready;
  assign seg_len  = (state_q == ST_STOP) ? stop_ticks : BIT_TICKS;
  assign seg_done = os_tick && !in_ready && (count == seg_len - 1'b1);
  assign clr      = load || seg_done;
  assign shift    = seg_done && (state_q == ST_DATA);
  assign last_bit = (idx_q == nbits - 1'b1);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          state_d = ST_START;
          idx_d   = '0;
        end
      end
      ST_START:  if (seg_done) state_d = ST_DATA;
      ST_DATA: begin
        if (seg_done) begin
          if (last_bit) state_d = par_en ? ST_PARITY : ST_STOP;
          else          idx_d   = idx_q + 1'b1;
        end
      end
      ST_PARITY: if (seg_done) state_d = ST_STOP;
      ST_STOP:   if (seg_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_START:  txd = 1'b0;
      ST_DATA:   txd = data_lsb;
      ST_PARITY: txd = par_bit;
      default:   txd = 1'b1;
    endcase
  end

endmodule

// File: rtl/serial_tx_framer.sv
module serial_tx_framer
  import serial_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MIN_LEN    = 5,
  parameter int OVERSAMPLE = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   os_tick,
  input  logic                                   in_valid,
  output logic                                   in_ready,
  input  logic [DATA_W-1:0]                      in_data,
  input  logic [$clog2(DATA_W-MIN_LEN+1)-1:0]    cfg_len,
  input  logic                                   cfg_par_en,
  input  logic                                   cfg_par_odd,
  input  logic [1:0]                             cfg_stop,
  output logic                                   txd
);

  localparam int LEN_W = $clog2(DATA_W - MIN_LEN + 1);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam int CNT_W = $clog2(2 * OVERSAMPLE + 1);

  logic             load, shift, clr;
  logic             data_lsb, par_bit, par_en;
  logic [IDX_W-1:0] nbits;
  logic [CNT_W-1:0] stop_ticks;
  logic [CNT_W-1:0] count;

  tx_frame_capture #(
    .DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .OVERSAMPLE(OVERSAMPLE),
    .LEN_W(LEN_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_capture (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
    .in_data(in_data), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop),
    .data_lsb(data_lsb), .par_bit(par_bit), .par_en(par_en),
    .nbits(nbits), .stop_ticks(stop_ticks)
  );

  tx_tick_counter #(.CNT_W(CNT_W)) u_ticks (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(os_tick), .count(count)
  );

  tx_sequencer #(
    .OVERSAMPLE(OVERSAMPLE), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .os_tick(os_tick),
    .data_lsb(data_lsb), .par_bit(par_bit), .par_en(par_en),
    .nbits(nbits), .stop_ticks(stop_ticks), .count(count),
    .in_ready(in_ready), .txd(txd), .load(load), .shift(shift), .clr(clr)
  );

endmodule

// File: rtl/serial_tx_checker.sv
module serial_tx_checker #(
  parameter int OVERSAMPLE = 16
) (
  input logic clk,
  input logic rst_n,
  input logic os_tick,
  input logic in_valid,
  input logic in_ready,
  input logic txd
);

  // Consecutive high ticks seen on the line during the current frame.
  logic [7:0] hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                     hi_run <= '0;
    else if (in_valid && in_ready)  hi_run <= '0;
    else if (os_tick && !in_ready)  hi_run <= txd ? ((hi_run == 8'hFF) ? hi_run : hi_run + 1'b1) : 8'h00;
  end

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> txd);

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!txd && !in_ready));

  p_stop_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> (32'(hi_run) >= OVERSAMPLE));

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && in_valid && !os_tick) |=> !in_ready);

  p_tick_paced_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(os_tick) && !$past(in_valid && in_ready)) |-> ($stable(txd) && $stable(in_ready)));

endmodule

bind serial_tx_framer serial_tx_checker #(.OVERSAMPLE(OVERSAMPLE)) u_serial_tx_checker (
  .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
  .in_valid(in_valid), .in_ready(in_ready), .txd(txd)
);

// File: tb/serial_tx_framer_bench.sv
`timescale 1ns/1ps
module serial_tx_framer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic [1:0] cfg_len = '0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic [1:0] cfg_stop = '0;
  logic       txd;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  serial_tx_framer u_serial_tx_framer (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop(cfg_stop), .txd(txd)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic [7:0] d, input int lenc, input int pen,
                           input int podd, input int stopc, input int period,
                           input bit poke, input bit freeze);
    int n, stop_t, total_t, k, phase, guard, j;
    int e2, e3, e4, e5;
    logic [7:0] m;
    logic par, e, held;
    bit froze, fz_ok;
    n       = 5 + lenc;
    m       = d & 8'((1 << n) - 1);
    par     = (^m) ^ podd[0];
    stop_t  = (stopc == 0) ? 16 : ((stopc == 1) ? 24 : 32);
    total_t = 16 * (1 + n + pen) + stop_t;
    e2 = 0; e3 = 0; e4 = 0; e5 = 0;
    k = 0; phase = 0; guard = 0; froze = 0; fz_ok = 1;

    @(negedge clk);
    os_tick = 1'b0; in_valid = 1'b1; in_data = d;
    cfg_len = 2'(lenc); cfg_par_en = pen[0]; cfg_par_odd = podd[0];
    cfg_stop = 2'(stopc);
    @(negedge clk);
    // R8: scramble everything once the handshake has happened
    in_valid = 1'b0; in_data = ~d; cfg_len = ~2'(lenc);
    cfg_par_en = ~pen[0]; cfg_par_odd = ~podd[0]; cfg_stop = 2'(stopc + 1);

    while (!in_ready && guard < 5000) begin
      if (freeze && !froze && k == 50) begin
        froze   = 1;
        held    = txd;
        os_tick = 1'b0;
        for (int w = 0; w < 30; w++) begin
          @(negedge clk);
          if (txd !== held || in_ready !== 1'b0) fz_ok = 0;
        end
      end
      os_tick = (phase == 0);
      phase   = (phase + 1) % period;
      if (os_tick) begin
        if (k < 16) e = 1'b0;
        else begin
          j = (k - 16) / 16;
          if (j < n)                  e = d[j];
          else if (j == n && pen != 0) e = par;
          else                         e = 1'b1;
        end
        if (txd !== e) begin
          if (k < 16)                       e2++;
          else if (k < 16 * (1 + n))        e3++;
          else if (k < 16 * (1 + n + pen))  e4++;
          else                              e5++;
        end
        k++;
      end
      if (poke) begin
        if (k == 40) begin in_valid = 1'b1; in_data = 8'h00; end
        if (k == 60) in_valid = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    os_tick = 1'b0;

    check(e2 == 0, "R2", "start-bit tick mismatches", e2, 0);
    check(e3 == 0, "R3", "data-bit tick mismatches (R9 masking)", e3, 0);
    check(e4 == 0, "R4", "parity tick mismatches", e4, 0);
    check(e5 == 0, "R5", "stop tick mismatches", e5, 0);
    check(k == total_t, "R5", "frame length in ticks (R6 ready timing)", k, total_t);
    check((e2 + e3 + e4 + e5) == 0, "R8", "frame altered by mid-frame input change",
          e2 + e3 + e4 + e5, 0);
    check(txd === 1'b1, "R1", "line level once ready", int'(txd), 1);
    if (poke)   check((e2 + e3 + e4 + e5) == 0 && k == total_t, "R7",
                      "load while busy disturbed frame", k, total_t);
    if (freeze) check(fz_ok, "R10", "line moved without tick", int'(fz_ok), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", "run did not finish", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int idx;
    repeat (5) @(negedge clk);
    check(in_ready === 1'b1, "R1", "ready during reset", int'(in_ready), 1);
    check(txd === 1'b1, "R1", "line during reset", int'(txd), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(in_ready === 1'b1 && txd === 1'b1, "R1", "idle after reset",
          int'({in_ready, txd}), 3);

    // R9 corners: only upper bits set, and all ones at 5 bits
    run_frame(8'hE0, 0, 1, 0, 0, 1, 1'b0, 1'b0);
    run_frame(8'hFF, 0, 1, 1, 1, 2, 1'b1, 1'b1);

    idx = 0;
    for (int lc = 0; lc < 4; lc++)
      for (int pe = 0; pe < 2; pe++)
        for (int po = 0; po < 2; po++)
          for (int sc = 0; sc < 4; sc++) begin
            run_frame(8'(idx * 73 + 29), lc, pe, po, sc, 1,
                      (idx % 5) == 0, (idx % 7) == 3);
            run_frame(8'(idx * 151 + 90) ^ 8'hA5, lc, pe, po, sc, 3,
                      (idx % 4) == 1, (idx % 6) == 2);
            idx++;
          end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule